// File: doc/BRIEF.md
# Translation-Invalidate Permission Checker

This block sits beside the instruction decode path. It decides whether an address-translation invalidate or fence instruction may run, or whether it must trap, given the hart's current privilege mode and two trap-control bits. The pipeline presents a strobe together with the 32-bit instruction word, the mode and the two control bits. One cycle later the block returns exactly one verdict: allow, illegal-instruction, virtual-instruction, or not-mine for words outside its encoding space. A trap verdict comes with its cause code.

The instructions fall into three permission families. Each family holds one batched-invalidate form and the fence form that shares its rules: supervisor-VMA, guest-virtual-VMA and guest-physical-VMA. Two further forms only order batched invalidations, and they are never trapped by this block. The block does not carry out any invalidation and does not look at address-space or VM identifier values.

Top module: `tlbinv_perm_check`

## Requirements
- R1: A word is in scope only when bits [6:0]=1110011, bits [14:12]=000 and bits [11:7]=0. Bits [31:25] select the form: 0001011/0001001 supervisor family, 0010011/0010001 guest-virtual family, 0110011/0110001 guest-physical family. 0001100 is an ordering form when bits [19:15]=0 and bits [24:20] is 0 or 1. Any other word yields only the not-mine flag.
- R2: Mode encoding is 00=U, 01=S/HS, 10=VU, 11=VS. In U mode, every form of all three families yields illegal-instruction, whatever the control bits are.
- R3: In S/HS mode, the supervisor and guest-physical families yield illegal-instruction when the translation-trap bit is 1 and are allowed when it is 0. The guest-virtual family is always allowed in this mode. The virtual-trap bit has no effect in this mode.
- R4: In VS or VU mode, the guest-virtual and guest-physical families yield virtual-instruction, whatever the control bits are.
- R5: In VU mode, the supervisor family yields virtual-instruction.
- R6: In VS mode, the supervisor family yields virtual-instruction when the virtual-trap bit is 1 and is allowed when it is 0. The translation-trap bit has no effect in this mode.
- R7: The fence form of each family gets the same verdict as the invalidate form of that family, under every mode and control-bit setting.
- R8: The two ordering forms are allowed in every mode under every control-bit setting.
- R9: With a valid result, exactly one of allow, illegal, virtual and not-mine is 1. The cause is 2 for illegal, 22 for virtual, and 0 otherwise.
- R10: The result appears with its valid flag exactly one cycle after the strobe. A cycle without a strobe yields all outputs 0 in the next cycle.
- R11: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_strobe | input | 1 | Request valid |
| i_instr | input | 32 | Instruction word |
| i_priv | input | 2 | Current mode (00 U, 01 S/HS, 10 VU, 11 VS) |
| i_tvm | input | 1 | Translation-trap control bit |
| i_vtvm | input | 1 | Virtual-translation-trap control bit |
| o_valid | output | 1 | Result valid |
| o_allow | output | 1 | Instruction may execute |
| o_illegal | output | 1 | Raise illegal-instruction |
| o_virtual | output | 1 | Raise virtual-instruction |
| o_foreign | output | 1 | Word is outside this block's scope |
| o_cause | output | CAUSE_W | Trap cause code |

## Verification
A directed sweep runs every in-scope form under all four modes and all four control-bit settings. This separates the effect of mode from the effect of each control bit, and it shows that the fence form and the invalidate form of a family get the same verdict. Random requests then mix in-scope words with arbitrary register fields and words with a corrupted opcode, funct3, rd or ordering-form operand. These show where the scope boundary lies, and they show that register fields do not affect the verdict. Idle cycles placed between back-to-back strobes show whether each result is tied to its own request cycle.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

  typedef enum logic [1:0] {
    PRV_U  = 2'b00,
    PRV_S  = 2'b01,
    PRV_VU = 2'b10,
    PRV_VS = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_SFAM  = 3'd1,
    OP_VVFAM = 3'd2,
    OP_GVFAM = 3'd3,
    OP_ORDER = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    V_ALLOW   = 2'd0,
    V_ILL     = 2'd1,
    V_VIRT    = 2'd2,
    V_FOREIGN = 2'd3
  } verdict_e;

  localparam logic [6:0] OPC_SYSTEM   = 7'b1110011;
  localparam logic [6:0] F7_S_INV     = 7'b0001011;
  localparam logic [6:0] F7_S_FEN     = 7'b0001001;
  localparam logic [6:0] F7_VV_INV    = 7'b0010011;
  localparam logic [6:0] F7_VV_FEN    = 7'b0010001;
  localparam logic [6:0] F7_GV_INV    = 7'b0110011;
  localparam logic [6:0] F7_GV_FEN    = 7'b0110001;
  localparam logic [6:0] F7_ORDER     = 7'b0001100;
  localparam int         CAUSE_ILLEGAL = 2;
  localparam int         CAUSE_VIRTUAL = 22;

  function automatic op_e classify(input logic [31:0] w);
    op_e r;
    r = OP_NONE;
    if (w[6:0] == OPC_SYSTEM && w[14:12] == 3'b000 && w[11:7] == 5'd0) begin
      unique case (w[31:25])
        F7_S_INV,  F7_S_FEN:  r = OP_SFAM;
        F7_VV_INV, F7_VV_FEN: r = OP_VVFAM;
        F7_GV_INV, F7_GV_FEN: r = OP_GVFAM;
        F7_ORDER:
          if (w[19:15] == 5'd0 && w[24:21] == 4'd0) r = OP_ORDER;
        default: r = OP_NONE;
      endcase
    end
    return r;
  endfunction

  // Illegal conditions are tested before virtual ones: fixed precedence.
  function automatic verdict_e judge(input op_e op, input priv_e pm,
                                     input logic tvm, input logic vtvm);
    logic fam;
    fam = (op == OP_SFAM) || (op == OP_VVFAM) || (op == OP_GVFAM);
    if (op == OP_NONE)                                   return V_FOREIGN;
    if (op == OP_ORDER)                                  return V_ALLOW;
    if (fam && pm == PRV_U)                              return V_ILL;
    if (pm == PRV_S && tvm && (op == OP_SFAM || op == OP_GVFAM)) return V_ILL;
    if ((pm == PRV_VS || pm == PRV_VU) && op != OP_SFAM) return V_VIRT;
    if (pm == PRV_VU)                                    return V_VIRT;
    if (pm == PRV_VS && vtvm)                            return V_VIRT;
    return V_ALLOW;
  endfunction

endpackage

// File: rtl/tlbchk_decode.sv
module tlbchk_decode
  import tlbchk_pkg::*;
#(
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0] instr,
  output op_e             op,
  output logic            inval_hit,
  output logic            order_hit
);
  always_comb begin
    op        = classify(instr[31:0]);
    inval_hit = (op == OP_SFAM) || (op == OP_VVFAM) || (op == OP_GVFAM);
    order_hit = (op == OP_ORDER);
  end
endmodule

// File: rtl/tlbchk_rules.sv
module tlbchk_rules
  import tlbchk_pkg::*;
(
  input  op_e      op,
  input  priv_e    pm,
  input  logic     tvm,
  input  logic     vtvm,
  output verdict_e verdict
);
  always_comb verdict = judge(op, pm, tvm, vtvm);
endmodule

// File: rtl/tlbinv_perm_check.sv
module tlbinv_perm_check
  import tlbchk_pkg::*;
#(
  parameter int CAUSE_W = 6,
  parameter int ILEN    = 32,
  parameter int PRIV_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i_strobe,
  input  logic [ILEN-1:0]    i_instr,
  input  logic [PRIV_W-1:0]  i_priv,
  input  logic               i_tvm,
  input  logic               i_vtvm,
  output logic               o_valid,
  output logic               o_allow,
  output logic               o_illegal,
  output logic               o_virtual,
  output logic               o_foreign,
  output logic [CAUSE_W-1:0] o_cause
);
  localparam logic [CAUSE_W-1:0] C_ILL  = CAUSE_W'(CAUSE_ILLEGAL);
  localparam logic [CAUSE_W-1:0] C_VIRT = CAUSE_W'(CAUSE_VIRTUAL);

  op_e      op_w;
  verdict_e verdict_w;
  logic     w_inval_hit;
  logic     w_order_hit;
  priv_e    priv_w;

  assign priv_w = priv_e'(i_priv[1:0]);

  tlbchk_decode #(.ILEN(ILEN)) u_dec (
    .instr     (i_instr),
    .op        (op_w),
    .inval_hit (w_inval_hit),
    .order_hit (w_order_hit)
  );

  tlbchk_rules u_rules (
    .op      (op_w),
    .pm      (priv_w),
    .tvm     (i_tvm),
    .vtvm    (i_vtvm),
    .verdict (verdict_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid   <= 1'b0;
      o_allow   <= 1'b0;
      o_illegal <= 1'b0;
      o_virtual <= 1'b0;
      o_foreign <= 1'b0;
      o_cause   <= '0;
    end else begin
      o_valid   <= i_strobe;
      o_allow   <= i_strobe && (verdict_w == V_ALLOW);
      o_illegal <= i_strobe && (verdict_w == V_ILL);
      o_virtual <= i_strobe && (verdict_w == V_VIRT);
      o_foreign <= i_strobe && (verdict_w == V_FOREIGN);
      if (i_strobe && verdict_w == V_ILL)       o_cause <= C_ILL;
      else if (i_strobe && verdict_w == V_VIRT) o_cause <= C_VIRT;
      else                                      o_cause <= '0;
    end
  end
endmodule

// File: rtl/tlbchk_checker.sv
module tlbchk_checker #(
  parameter int CAUSE_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               i_strobe,
  input logic [1:0]         i_priv,
  input logic               w_inval_hit,
  input logic               w_order_hit,
  input logic               o_valid,
  input logic               o_allow,
  input logic               o_illegal,
  input logic               o_virtual,
  input logic               o_foreign,
  input logic [CAUSE_W-1:0] o_cause
);
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> $countones({o_allow, o_illegal, o_virtual, o_foreign}) == 1);

  assert_cause_ill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    o_illegal |-> o_cause == CAUSE_W'(2));

  assert_cause_virt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    o_virtual |-> o_cause == CAUSE_W'(22));

  assert_strobe_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    i_strobe |=> o_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !i_strobe |=> !o_valid && !o_allow && !o_illegal && !o_virtual && !o_foreign);

  assert_user_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_strobe && i_priv == 2'b00 && w_inval_hit) |=> o_illegal);

  assert_order_allow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (i_strobe && w_order_hit) |=> o_allow);

  assert_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (i_strobe && !w_inval_hit && !w_order_hit) |=> o_foreign);

  assert_virt_from_guest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (i_strobe && !i_priv[1]) |=> !o_virtual);
endmodule

bind tlbinv_perm_check tlbchk_checker #(.CAUSE_W(CAUSE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .i_strobe    (i_strobe),
  .i_priv      (i_priv),
  .w_inval_hit (w_inval_hit),
  .w_order_hit (w_order_hit),
  .o_valid     (o_valid),
  .o_allow     (o_allow),
  .o_illegal   (o_illegal),
  .o_virtual   (o_virtual),
  .o_foreign   (o_foreign),
  .o_cause     (o_cause)
);

// File: tb/tlbinv_perm_check_tb.sv
`timescale 1ns/1ps
module tlbinv_perm_check_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        i_strobe;
  logic [31:0] i_instr;
  logic [1:0]  i_priv;
  logic        i_tvm, i_vtvm;
  logic        o_valid, o_allow, o_illegal, o_virtual, o_foreign;
  logic [5:0]  o_cause;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tlbinv_perm_check u_dut (
    .clk(clk), .rst_n(rst_n), .i_strobe(i_strobe), .i_instr(i_instr),
    .i_priv(i_priv), .i_tvm(i_tvm), .i_vtvm(i_vtvm), .o_valid(o_valid),
    .o_allow(o_allow), .o_illegal(o_illegal), .o_virtual(o_virtual),
    .o_foreign(o_foreign), .o_cause(o_cause)
  );

  logic [6:0] forms [8] = '{7'h0B, 7'h09, 7'h13, 7'h11, 7'h33, 7'h31, 7'h0C, 7'h0C};

  // family: 0 none, 1 supervisor, 2 guest-virtual, 3 guest-physical, 4 ordering
  function automatic int family(input logic [31:0] w);
    logic [6:0] f7;
    f7 = w[31:25];
    if (!(w[6:0] == 7'b1110011 && w[14:12] == 3'd0 && w[11:7] == 5'd0)) return 0;
    if (f7 == 7'h0B || f7 == 7'h09) return 1;
    if (f7 == 7'h13 || f7 == 7'h11) return 2;
    if (f7 == 7'h33 || f7 == 7'h31) return 3;
    if (f7 == 7'h0C && w[19:15] == 5'd0 && w[24:20] <= 5'd1) return 4;
    return 0;
  endfunction

  // returns {allow, illegal, virtual, foreign}
  function automatic logic [3:0] model(input logic [31:0] w, input logic [1:0] m,
                                       input logic t, input logic vt);
    int k;
    k = family(w);
    if (k == 0) return 4'b0001;
    if (k == 4) return 4'b1000;
    case (m)
      2'b00: return 4'b0100;
      2'b01: return (t && k != 2) ? 4'b0100 : 4'b1000;
      2'b10: return 4'b0010;
      default: return (k != 1 || vt) ? 4'b0010 : 4'b1000;
    endcase
  endfunction

  function automatic string req_of(input logic [31:0] w, input logic [1:0] m);
    int k;
    k = family(w);
    if (k == 0) return "R1";
    if (k == 4) return "R8";
    if (w[26] == 1'b0) return "R7";
    if (m == 2'b00) return "R2";
    if (m == 2'b01) return "R3";
    if (k != 1) return "R4";
    return (m == 2'b10) ? "R5" : "R6";
  endfunction

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
                                     input logic [4:0] rs1);
    return {f7, rs2, rs1, 3'b000, 5'd0, 7'b1110011};
  endfunction

  task automatic compare(input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (valid,allow,ill,virt,foreign,cause)", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [31:0] w, input logic [1:0] m,
                      input logic t, input logic vt);
    logic [3:0] f;
    logic [5:0] c;
    i_strobe = s; i_instr = w; i_priv = m; i_tvm = t; i_vtvm = vt;
    @(negedge clk);
    f = s ? model(w, m, t, vt) : 4'b0000;
    c = f[2] ? 6'd2 : (f[1] ? 6'd22 : 6'd0);
    compare(s ? req_of(w, m) : "R10",
            {o_valid, o_allow, o_illegal, o_virtual, o_foreign, o_cause},
            {s, f, c});
    if (s && f[1]) compare("R9", {5'd0, o_cause}, 11'd22);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    rst_n = 1'b0; i_strobe = 1'b1; i_instr = mk(7'h0B, 0, 0);
    i_priv = 2'b00; i_tvm = 1'b1; i_vtvm = 1'b1;
    repeat (3) @(negedge clk);
    compare("R11", {o_valid, o_allow, o_illegal, o_virtual, o_foreign, o_cause}, 11'd0);
    rst_n = 1'b1;
    i_strobe = 1'b0;
    @(negedge clk);

    // directed sweep: all forms, modes, control bits
    for (int m = 0; m < 4; m++)
      for (int cb = 0; cb < 4; cb++)
        for (int f = 0; f < 8; f++)
          step(1'b1, mk(forms[f], (f == 7) ? 5'd1 : 5'd0, 5'd0), 2'(m), cb[0], cb[1]);

    // corner cases outside scope
    step(1'b1, mk(7'h0C, 5'd2, 5'd0), 2'b01, 1'b0, 1'b0);
    step(1'b1, mk(7'h0C, 5'd0, 5'd3), 2'b01, 1'b0, 1'b0);
    step(1'b1, mk(7'h0B, 5'd4, 5'd5) | 32'h0000_1000, 2'b00, 1'b0, 1'b0);
    step(1'b1, mk(7'h13, 5'd0, 5'd0) | 32'h0000_0080, 2'b11, 1'b0, 1'b0);
    step(1'b1, 32'h0000_0013, 2'b00, 1'b0, 1'b0);
    step(1'b0, mk(7'h0B, 0, 0), 2'b00, 1'b0, 1'b0);

    // constrained random mix
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] w;
      logic [31:0] r;
      r = $urandom;
      w = mk(forms[r[2:0]], (r[5:3] == 3'd0) ? 5'(r[8:6]) : 5'(r[12:9] & 4'h1),
             (r[15:13] == 3'd0) ? 5'(r[20:16]) : 5'd0);
      if (r[3:0] == 4'd1) w[25] = ~w[25];
      if (r[7:4] == 4'd2) w[13] = 1'b1;
      if (r[7:4] == 4'd3) w[9]  = 1'b1;
      if (r[7:4] == 4'd4) w[2]  = 1'b0;
      if (r[7:4] == 4'd5) w = $urandom;
      step(r[31:29] != 3'd0, w, r[22:21], r[23], r[24]);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule